// File: doc/BRIEF.md
# Flash Command Mailbox

A device-side mailbox that lets a host run flash operations by writing and reading a small window of 32-bit registers over a synchronous register port. The host loads up to sixteen data words, then writes a command word with its request bit set. The block copies words between the data registers and a behavioural flash array, one word per fixed time slot. When it is done it writes a status word, clears the request bit and returns to idle. The host polls the command word until the request bit reads 0 and then reads the status.

The flash model holds two equal regions. One is active and serves reads. The other is inactive and takes writes. A separate small header area is used when the command's header flag is set. An authenticate command swaps the two regions if the inactive image starts with a magic word. A power-cycle command only pulses an output pin.

Top module: `flash_cmd_mailbox`

## Requirements
- R1: Register offsets: data words at offsets 1..16 (offset 1+i is data word i), command word at 17, status word at 18. Data and command words read back what was last written to them. The status word is read-only. Every other offset reads 0, and writes to it are ignored.
- R2: Command word layout: bits 31:28 operation code, 27:24 count field, 23:2 word address, bit 1 header flag, bit 0 request. Writing the command word while idle with bit 0 = 0 only stores it and starts nothing.
- R3: Operation codes: 0 = write to flash, 1 = authenticate, 2 = read from flash, 4 = power cycle.
- R4: A read copies flash words address+i into data word i, for i below n, from the active region. n is 16 when the count field is 0; otherwise n is the count field. Data words at n and above are left unchanged.
- R5: A write copies data words 0..n-1 to inactive-region address+i, where n is the count field plus 1.
- R6: With the header flag set, reads and writes use the header area of HDR_DWORDS words instead of a region. A transfer with address+n above HDR_DWORDS is refused.
- R7: Authenticate swaps the active and inactive regions with status 0 when inactive word 0 equals MAGIC. Otherwise it returns status 1 and swaps nothing.
- R8: After each command the status word holds the result in bits 3:0 (0 done, 1 authentication error, 2 access error), the finished command's code in bits 7:4 and 1 in bit 29. All other bits are 0.
- R9: Bit 0 of the command word returns to 0 exactly n*CYCLES_PER_DWORD cycles after the starting write for an accepted transfer, and CYCLES_PER_DWORD cycles after it for every other command.
- R10: Codes other than 0, 1, 2 and 4, and transfers with address+n above the region size, end with status 2 and change neither flash nor the data words.
- R11: While a command is running, host writes to the data words and the command word are ignored.
- R12: A power-cycle command ends with status 0 and drives powerCycle high for exactly one cycle, the cycle in which the request bit first reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| regAddr | input | 5 | Register offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| powerCycle | output | 1 | One-cycle power-cycle pulse |

## Verification
The bench builds the block with 32-word regions, an 8-word header area and 3 cycles per word. With these sizes every count-field value can be combined with addresses that fit exactly, that end on the region's last word, and that overrun the region. Both the header-size limit and the region limit can then be hit with a short sweep. A flash model in the bench predicts every data word, status word and busy time. The written region is only visible after an authenticate, so the bench reads it back after swapping regions.

// File: rtl/fmbx_pkg.sv
package fmbx_pkg;
  localparam int DATA_WORDS = 16;
  localparam int CMD_OFS    = 17;
  localparam int STAT_OFS   = 18;

  localparam logic [3:0] OP_WRITE = 4'h0;
  localparam logic [3:0] OP_AUTH  = 4'h1;
  localparam logic [3:0] OP_READ  = 4'h2;
  localparam logic [3:0] OP_POWER = 4'h4;

  localparam logic [3:0] ST_OK     = 4'd0;
  localparam logic [3:0] ST_AUTH   = 4'd1;
  localparam logic [3:0] ST_ACCESS = 4'd2;

  typedef struct packed {
    logic       toFlash;
    logic       toRegs;
    logic       useHdr;
    logic       swap;
    logic       power;
    logic       finish;
    logic [3:0] status;
    logic [3:0] idx;
  } fmbx_strobe_t;
endpackage

// File: rtl/fmbx_ctrl.sv
module fmbx_ctrl
  import fmbx_pkg::*;
#(
  parameter int FLASH_DWORDS     = 64,
  parameter int HDR_DWORDS       = 16,
  parameter int CYCLES_PER_DWORD = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         startReq,
  input  logic [31:1]  cmdWord,
  input  logic         authValid,
  output fmbx_strobe_t strb,
  output logic         busy
);
  localparam int CYC_W = (CYCLES_PER_DWORD > 1) ? $clog2(CYCLES_PER_DWORD) : 1;

  logic [3:0]  opCode;
  logic [3:0]  cntField;
  logic [21:0] wordAddr;
  logic        hdrFlag;
  logic        isRd, isWr, known, rangeOk, xferOk;
  logic [4:0]  nWords, steps;
  logic [31:0] limit;

  logic             busyQ;
  logic [CYC_W-1:0] cycQ;
  logic [4:0]       idxQ;
  logic             stepNow, lastStep;

  always_comb begin
    opCode   = cmdWord[31:28];
    cntField = cmdWord[27:24];
    wordAddr = cmdWord[23:2];
    hdrFlag  = cmdWord[1];
    isRd     = (opCode == OP_READ);
    isWr     = (opCode == OP_WRITE);
    known    = isRd || isWr || (opCode == OP_AUTH) || (opCode == OP_POWER);
    if (isRd) nWords = (cntField == 4'd0) ? 5'd16 : {1'b0, cntField};
    else      nWords = {1'b0, cntField} + 5'd1;
    limit    = hdrFlag ? 32'(HDR_DWORDS) : 32'(FLASH_DWORDS);
    rangeOk  = (32'(wordAddr) + 32'(nWords)) <= limit;
    xferOk   = (isRd || isWr) && rangeOk;
    steps    = xferOk ? nWords : 5'd1;
  end

  assign stepNow  = busyQ && (cycQ == CYC_W'(CYCLES_PER_DWORD - 1));
  assign lastStep = stepNow && (idxQ == steps - 5'd1);
  assign busy     = busyQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      cycQ  <= '0;
      idxQ  <= '0;
    end else if (startReq) begin
      busyQ <= 1'b1;
      cycQ  <= '0;
      idxQ  <= '0;
    end else if (busyQ) begin
      if (stepNow) begin
        cycQ <= '0;
        idxQ <= idxQ + 5'd1;
        if (lastStep) busyQ <= 1'b0;
      end else begin
        cycQ <= cycQ + CYC_W'(1);
      end
    end
  end

  always_comb begin
    strb.toFlash = stepNow && xferOk && isWr;
    strb.toRegs  = stepNow && xferOk && isRd;
    strb.useHdr  = hdrFlag;
    strb.swap    = lastStep && (opCode == OP_AUTH) && authValid;
    strb.power   = lastStep && (opCode == OP_POWER);
    strb.finish  = lastStep;
    strb.idx     = idxQ[3:0];
    if (!known || ((isRd || isWr) && !rangeOk)) strb.status = ST_ACCESS;
    else if ((opCode == OP_AUTH) && !authValid)  strb.status = ST_AUTH;
    else                                         strb.status = ST_OK;
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.toFlash, strb.toRegs, strb.swap, strb.power})); // R10
  AST_FINISH_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    strb.finish |=> !busy); // R9
endmodule

// File: rtl/fmbx_dp.sv
module fmbx_dp
  import fmbx_pkg::*;
#(
  parameter int          FLASH_DWORDS = 64,
  parameter int          HDR_DWORDS   = 16,
  parameter logic [31:0] MAGIC        = 32'hA5C3_0F1E
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [4:0]   regAddr,
  input  logic         regWrEn,
  input  logic [31:0]  regWrData,
  input  logic         busy,
  input  fmbx_strobe_t strb,
  output logic [31:0]  regRdData,
  output logic [31:0]  cmdWord,
  output logic         authValid,
  output logic         powerCycle
);
  localparam int FA_W = $clog2(FLASH_DWORDS);
  localparam int HA_W = $clog2(HDR_DWORDS);

  logic [31:0] dataQ  [DATA_WORDS];
  logic [31:0] flashQ [2][FLASH_DWORDS];
  logic [31:0] hdrQ   [HDR_DWORDS];
  logic        activeQ;
  logic [31:0] cmdQ, statQ;
  logic        pwrQ;

  logic            isData;
  logic [3:0]      dataIdx;
  logic [FA_W-1:0] flashIdx;
  logic [HA_W-1:0] hdrIdx;
  logic [DATA_WORDS*32-1:0] dataFlat;

  assign isData   = (regAddr >= 5'd1) && (regAddr <= 5'(DATA_WORDS));
  assign dataIdx  = 4'(regAddr - 5'd1);
  assign flashIdx = cmdQ[2 +: FA_W] + FA_W'(strb.idx);
  assign hdrIdx   = cmdQ[2 +: HA_W] + HA_W'(strb.idx);

  for (genvar g = 0; g < DATA_WORDS; g++) begin : gFlat
    assign dataFlat[g*32 +: 32] = dataQ[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DATA_WORDS; i++) dataQ[i] <= '0;
      for (int r = 0; r < 2; r++)
        for (int i = 0; i < FLASH_DWORDS; i++) flashQ[r][i] <= '0;
      for (int i = 0; i < HDR_DWORDS; i++) hdrQ[i] <= '0;
      activeQ <= 1'b0;
      cmdQ    <= '0;
      statQ   <= '0;
      pwrQ    <= 1'b0;
    end else begin
      if (regWrEn && !busy) begin
        if (isData) dataQ[dataIdx] <= regWrData;
        if (regAddr == 5'(CMD_OFS)) cmdQ <= regWrData;
      end
      if (strb.toRegs)
        dataQ[strb.idx] <= strb.useHdr ? hdrQ[hdrIdx] : flashQ[activeQ][flashIdx];
      if (strb.toFlash) begin
        if (strb.useHdr) hdrQ[hdrIdx] <= dataQ[strb.idx];
        else             flashQ[~activeQ][flashIdx] <= dataQ[strb.idx];
      end
      if (strb.swap) activeQ <= ~activeQ;
      if (strb.finish) begin
        cmdQ[0] <= 1'b0;
        statQ   <= {2'b00, 1'b1, 21'd0, cmdQ[31:28], strb.status};
      end
      pwrQ <= strb.power;
    end
  end

  always_comb begin
    if (isData)                        regRdData = dataQ[dataIdx];
    else if (regAddr == 5'(CMD_OFS))   regRdData = cmdQ;
    else if (regAddr == 5'(STAT_OFS))  regRdData = statQ;
    else                               regRdData = '0;
  end

  assign cmdWord    = cmdQ;
  assign authValid  = (flashQ[~activeQ][0] == MAGIC);
  assign powerCycle = pwrQ;

  AST_BUSY_DATA_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && regWrEn && isData && !strb.toRegs) |=> $stable(dataFlat)); // R11
  AST_REQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    strb.finish |=> !cmdQ[0]); // R9
  AST_STATUS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    strb.finish |=> (statQ[7:4] == $past(cmdQ[31:28])) && statQ[29]); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pwrQ |=> !pwrQ); // R12
endmodule

// File: rtl/flash_cmd_mailbox.sv
module flash_cmd_mailbox
  import fmbx_pkg::*;
#(
  parameter int          FLASH_DWORDS     = 64,
  parameter int          HDR_DWORDS       = 16,
  parameter int          CYCLES_PER_DWORD = 2,
  parameter logic [31:0] MAGIC            = 32'hA5C3_0F1E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        powerCycle
);
  fmbx_strobe_t strb;
  logic         busy, startReq, authValid;
  logic [31:0]  cmdWord;

  assign startReq = regWrEn && (regAddr == 5'(CMD_OFS)) && regWrData[0] && !busy;

  fmbx_ctrl #(
    .FLASH_DWORDS(FLASH_DWORDS), .HDR_DWORDS(HDR_DWORDS),
    .CYCLES_PER_DWORD(CYCLES_PER_DWORD)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .cmdWord(cmdWord[31:1]),
    .authValid(authValid), .strb(strb), .busy(busy)
  );

  fmbx_dp #(
    .FLASH_DWORDS(FLASH_DWORDS), .HDR_DWORDS(HDR_DWORDS), .MAGIC(MAGIC)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .busy(busy), .strb(strb), .regRdData(regRdData),
    .cmdWord(cmdWord), .authValid(authValid), .powerCycle(powerCycle)
  );
endmodule

// File: tb/test_flash_cmd_mailbox.sv
module test_flash_cmd_mailbox;
  localparam int          FD    = 32;
  localparam int          HD    = 8;
  localparam int          CPD   = 3;
  localparam logic [31:0] MAGIC = 32'h5AFE_C0DE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        powerCycle;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  logic [31:0] refData [16];
  logic [31:0] refFlash [2][FD];
  logic [31:0] refHdr [HD];
  int          refAct = 0;
  logic [31:0] refStat = '0;

  always #4 clk = ~clk;

  flash_cmd_mailbox #(.FLASH_DWORDS(FD), .HDR_DWORDS(HD),
    .CYCLES_PER_DWORD(CPD), .MAGIC(MAGIC)) i_flash_cmd_mailbox (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .powerCycle(powerCycle));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input int a, input logic [31:0] d);
    @(negedge clk);
    regAddr = 5'(a); regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic regRead(input int a, output logic [31:0] d);
    regAddr = 5'(a);
    #1 d = regRdData;
  endtask

  task automatic fillData(input int seed);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] v;
      v = 32'h1000_0000 * 32'(seed % 16) + 32'(seed * 64 + i * 7 + 1);
      regWrite(i + 1, v);
      refData[i] = v;
    end
  endtask

  task automatic checkData(input string req);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] v;
      regRead(i + 1, v);
      check(req, v, refData[i]);
    end
  endtask

  function automatic void model(input logic [31:0] w, output logic [3:0] st, output int cyc);
    int code, cf, a, n, lim;
    bit hdr, ok;
    code = int'(w[31:28]); cf = int'(w[27:24]); a = int'(w[23:2]); hdr = w[1];
    n = (code == 2) ? ((cf == 0) ? 16 : cf) : cf + 1;
    lim = hdr ? HD : FD;
    ok = (a + n) <= lim;
    st = 4'd0;
    cyc = CPD;
    case (code)
      2: if (ok) begin
           for (int i = 0; i < n; i++) refData[i] = hdr ? refHdr[a+i] : refFlash[refAct][a+i];
           cyc = n * CPD;
         end else st = 4'd2;
      0: if (ok) begin
           for (int i = 0; i < n; i++)
             if (hdr) refHdr[a+i] = refData[i]; else refFlash[1-refAct][a+i] = refData[i];
           cyc = n * CPD;
         end else st = 4'd2;
      1: if (refFlash[1-refAct][0] == MAGIC) refAct = 1 - refAct; else st = 4'd1;
      4: st = 4'd0;
      default: st = 4'd2;
    endcase
  endfunction

  function automatic logic [31:0] mkCmd(input int code, input int cf, input int a, input bit hdr);
    return {4'(code), 4'(cf), 22'(a), hdr, 1'b1};
  endfunction

  task automatic runCmd(input string req, input logic [31:0] w);
    logic [3:0] st; int cyc; int cnt; int pwrCnt; logic [31:0] v; logic [31:0] expStat;
    model(w, st, cyc);
    regWrite(17, w);
    cnt = 0; pwrCnt = 0;
    do begin
      @(posedge clk); cnt++;
      #2 regRead(17, v);
      if (powerCycle) pwrCnt++;
    end while (v[0] && cnt < 2000);
    check({req, " R9 busy cycles"}, 32'(cnt), 32'(cyc));
    check({req, " R9 request cleared"}, v, {w[31:1], 1'b0});
    expStat = {2'b00, 1'b1, 21'd0, w[31:28], st};
    refStat = expStat;
    regRead(18, v);
    check({req, " R8 status"}, v, expStat);
    @(posedge clk); #2;
    if (powerCycle) pwrCnt++;
    check({req, " R12 pulse count"}, 32'(pwrCnt), (w[31:28] == 4'h4) ? 32'd1 : 32'd0);
    checkData({req, " data words"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    automatic int addrW[4] = '{0, 3, 16, 30};
    automatic int addrR[4] = '{0, 7, 20, 31};
    for (int i = 0; i < 16; i++) refData[i] = '0;
    for (int r = 0; r < 2; r++) for (int i = 0; i < FD; i++) refFlash[r][i] = '0;
    for (int i = 0; i < HD; i++) refHdr[i] = '0;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state
    for (int a = 0; a < 32; a++) begin regRead(a, v); check("R1 reset read", v, 32'd0); end
    check("R12 reset pulse", 32'(powerCycle), 32'd0);

    // R1 window
    fillData(1);
    checkData("R1 data readback");
    regWrite(0, 32'hFFFF_FFFF); regWrite(19, 32'hFFFF_FFFF); regWrite(31, 32'h1234_5678);
    regRead(0, v);  check("R1 offset 0", v, 32'd0);
    regRead(19, v); check("R1 offset 19", v, 32'd0);
    regRead(31, v); check("R1 offset 31", v, 32'd0);
    regWrite(18, 32'hFFFF_FFFF);
    regRead(18, v); check("R1 status read-only", v, 32'd0);
    checkData("R1 data after stray writes");

    // R2 idle store without request
    regWrite(17, 32'h2F00_0010);
    repeat (2) @(posedge clk); #2;
    regRead(17, v); check("R2 stored command", v, 32'h2F00_0010);
    regRead(18, v); check("R2 no start", v, 32'd0);

    // R5 R10 write sweep into inactive region
    for (int f = 0; f < 16; f++)
      for (int k = 0; k < 4; k++) begin
        fillData(f * 4 + k + 2);
        runCmd("R5 R10 write", mkCmd(0, f, addrW[k], 1'b0));
      end
    // R10 unknown codes
    for (int c = 3; c < 16; c++)
      if (c != 4) runCmd("R10 R3 unknown code", mkCmd(c, 1, 0, 1'b0));

    // R7 authenticate after planting magic
    fillData(99);
    regWrite(1, MAGIC); refData[0] = MAGIC;
    runCmd("R5 magic write", mkCmd(0, 0, 0, 1'b0));
    runCmd("R7 auth pass", mkCmd(1, 0, 0, 1'b0));

    // R4 read sweep on new active region
    for (int f = 0; f < 16; f++)
      for (int k = 0; k < 4; k++)
        runCmd("R4 R10 read", mkCmd(2, f, addrR[k], 1'b0));

    runCmd("R7 auth fail", mkCmd(1, 0, 0, 1'b0));
    runCmd("R7 R4 read after failed auth", mkCmd(2, 0, 0, 1'b0));

    // R6 header area
    fillData(200);
    runCmd("R6 header write full", mkCmd(0, 7, 0, 1'b1));
    fillData(201);
    runCmd("R6 header write oversize", mkCmd(0, 8, 0, 1'b1));
    runCmd("R6 header write tail", mkCmd(0, 2, 5, 1'b1));
    runCmd("R6 header read oversize", mkCmd(2, 0, 0, 1'b1));
    fillData(202);
    runCmd("R6 header read", mkCmd(2, 8, 0, 1'b1));
    runCmd("R6 R4 region untouched by header", mkCmd(2, 0, 16, 1'b0));

    // R12 power cycle
    runCmd("R12 power", mkCmd(4, 0, 0, 1'b0));

    // R11 writes while busy are ignored
    begin
      logic [3:0] st; int cyc; int pw; int cnt;
      logic [31:0] w;
      w = mkCmd(2, 2, 4, 1'b0);
      model(w, st, cyc);
      @(negedge clk); regAddr = 5'd17; regWrData = w; regWrEn = 1'b1;
      @(posedge clk); #1 regAddr = 5'd11; regWrData = 32'hDEAD_BEEF;
      @(posedge clk); #1 regAddr = 5'd17; regWrData = mkCmd(4, 0, 0, 1'b0);
      @(posedge clk); #1 regWrEn = 1'b0;
      pw = 0; cnt = 0;
      do begin
        @(posedge clk); cnt++;
        #2 regRead(17, v);
        if (powerCycle) pw++;
      end while (v[0] && cnt < 2000);
      check("R11 command kept", v, {w[31:1], 1'b0});
      regRead(18, v); check("R11 status echoes first command", v, {2'b00, 1'b1, 21'd0, 4'h2, st});
      repeat (4) begin @(posedge clk); #2; if (powerCycle) pw++; end
      check("R11 ignored command did not run", 32'(pw), 32'd0);
      regRead(17, v); check("R11 no second request", 32'(v[0]), 32'd0);
      checkData("R11 data word untouched");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule